// File: doc/BRIEF.md
# Global-slot process ready scheduler

This block lets a cooperative software loop run its processes on a shared timing grid. It holds eight period timers. Software programs each one in milliseconds, and each one counts down on a 1 ms tick input. Each of 32 process entries is bound to one of the eight timers. When the bound timer runs out, the entry raises its ready flag. Software polls the ready flags as one word and clears each flag once it has run that process. A single command restarts all eight timers together, so every slot keeps a fixed phase relative to the others.

Each entry can also be given a one-shot delay in milliseconds. While the delay runs, the entry ignores its periodic timer. When the delay ends, the entry becomes ready exactly once. A control command can cancel a running delay.

Each process entry is a two-state machine, with states `PS_PERIODIC` and `PS_DELAYED`:
- PERIODIC→DELAYED: a delay write with a non-zero value.
- DELAYED→PERIODIC: the delay runs out, which sets ready; or a cancel command, which does not set ready; or a delay write of zero, which sets ready.
- DELAYED→DELAYED: a new non-zero delay write restarts the count.

Top module: `slot_sched`

## Requirements
- R1: After reset every ready bit reads 0, every period is 0 and every entry is bound to timer 0.
- R2: Register address 0 is the control register. A write with bit 1 set loads timer `wr_data[10:8]` with the period in `wr_data[31:16]`. That timer then expires on every Pth tick after the load, and each expiry sets the ready bit of every entry in the periodic state that is bound to the timer. The new ready bit can be read one clock after the tick.
- R3: A timer whose period is 0 never expires.
- R4: A control write with bit 2 set restarts every timer at its full period on the same clock, so timers with equal periods expire together afterwards.
- R5: A write to address 1 binds process `wr_data[20:16]` to timer `wr_data[2:0]`. The entry responds only to expiries of the timer it is bound to.
- R6: `ready_word` bit p is process p's ready flag. Writing address 3 clears each flag whose data bit is 1 and leaves a flag unchanged where the data bit is 0.
- R7: A ready flag that is still set when its timer expires again stays set, and one clear removes it. No count of missed expiries is kept.
- R8: A write to address 2 gives process `wr_data[20:16]` a delay of `wr_data[15:0]` ms, with the value non-zero. The flag is not set by periodic expiries during the delay and is set on the Dth tick after the write. Periodic setting resumes after that tick.
- R9: A control write with bit 0 set cancels the delay of process `wr_data[12:8]` without setting its flag, and periodic setting resumes.
- R10: A delay write with value 0 sets the flag on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 control, 1 bind, 2 delay, 3 ready clear |
| wr_data | input | 32 | Write data |
| ready_word | output | 32 | Ready flags, one per process |

## Verification
A timer counter that is off by one shows up as a ready flag rising one tick early or late. This is visible at `ready_word` within one period of the faulty timer. A phase error left after a reset-all shows up as two equal-period slots flagging on different ticks, at the first expiry after the command. An entry stuck in the wrong state shows up either as a periodic flag that appears during a delay, or as a flag that never returns after the delay ends or is cancelled. Either fault is visible within one period of the bound timer.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;
    localparam int NTIMERS = 8;
    localparam int TSEL_W  = $clog2(NTIMERS);
    localparam int PER_W   = 16;

    typedef enum logic {
        PS_PERIODIC = 1'b0,
        PS_DELAYED  = 1'b1
    } pstate_e;
endpackage

// File: rtl/slot_timer.sv
module slot_timer
    import slot_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load,
    input  logic [PER_W-1:0] load_val,
    input  logic             sync,
    output logic             expire
);
    logic [PER_W-1:0] period;
    logic [PER_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period <= '0;
            cnt    <= '0;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                period <= load_val;
                cnt    <= load_val;
            end else if (sync) begin
                cnt <= period;
            end else if (tick && period != '0) begin
                if (cnt <= 1) begin
                    cnt    <= period;
                    expire <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

    // R3: a disabled timer stays silent
    a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (period == '0 && !load) |=> !expire);
    // R2: expiry only follows a tick
    a_r2_expire_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> $past(tick));
endmodule

// File: rtl/proc_entry.sv
module proc_entry
    import slot_sched_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [NTIMERS-1:0] expire_vec,
    input  logic               bind_we,
    input  logic [TSEL_W-1:0]  bind_val,
    input  logic               delay_we,
    input  logic [PER_W-1:0]   delay_val,
    input  logic               cancel,
    input  logic               clr,
    output logic               ready
);
    pstate_e            st, st_n;
    logic [PER_W-1:0]   dcnt, dcnt_n;
    logic [TSEL_W-1:0]  bound;
    logic               fire;
    logic               periodic_hit;

    always_comb begin
        st_n   = st;
        dcnt_n = dcnt;
        fire   = 1'b0;
        unique case (st)
            PS_PERIODIC: begin
                if (delay_we) begin
                    if (delay_val == '0) begin
                        fire = 1'b1;
                    end else begin
                        st_n   = PS_DELAYED;
                        dcnt_n = delay_val;
                    end
                end
            end
            PS_DELAYED: begin
                if (delay_we) begin
                    if (delay_val == '0) begin
                        fire = 1'b1;
                        st_n = PS_PERIODIC;
                    end else begin
                        dcnt_n = delay_val;
                    end
                end else if (cancel) begin
                    st_n = PS_PERIODIC;
                end else if (tick) begin
                    if (dcnt <= 1) begin
                        fire = 1'b1;
                        st_n = PS_PERIODIC;
                    end else begin
                        dcnt_n = dcnt - 1'b1;
                    end
                end
            end
        endcase
    end

    assign periodic_hit = (st == PS_PERIODIC) && expire_vec[bound];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= PS_PERIODIC;
            dcnt  <= '0;
            bound <= '0;
        end else begin
            st   <= st_n;
            dcnt <= dcnt_n;
            if (bind_we) bound <= bind_val;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n)                    ready <= 1'b0;
        else if (fire || periodic_hit) ready <= 1'b1;
        else if (clr)                  ready <= 1'b0;
    end

    // R7: flag holds until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !clr) |=> ready);
    // R8: no periodic setting while delayed
    a_r8_suppressed: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_DELAYED && !ready && !delay_we && !(tick && dcnt <= 1)) |=> !ready);
    // R9: cancel does not raise the flag
    a_r9_cancel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == PS_DELAYED && cancel && !delay_we && !ready) |=> (!ready && st == PS_PERIODIC));
endmodule

// File: rtl/slot_sched.sv
module slot_sched
    import slot_sched_pkg::*;
#(
    parameter int NPROC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_ms,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [31:0]      wr_data,
    output logic [NPROC-1:0] ready_word
);
    localparam int PIDX_W = $clog2(NPROC);

    logic               ctrl_we, bind_we, delay_we, clr_we;
    logic [2:0]         cmd;
    logic [TSEL_W-1:0]  tsel;
    logic [PIDX_W-1:0]  cancel_sel, upper_sel;
    logic [NTIMERS-1:0] expire_vec;

    assign ctrl_we    = wr_en && wr_addr == 2'd0;
    assign bind_we    = wr_en && wr_addr == 2'd1;
    assign delay_we   = wr_en && wr_addr == 2'd2;
    assign clr_we     = wr_en && wr_addr == 2'd3;
    assign cmd        = wr_data[2:0];
    assign tsel       = wr_data[8 +: TSEL_W];
    assign cancel_sel = wr_data[8 +: PIDX_W];
    assign upper_sel  = wr_data[16 +: PIDX_W];

    for (genvar t = 0; t < NTIMERS; t++) begin : g_timer
        slot_timer u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick_ms),
            .load     (ctrl_we && cmd[1] && tsel == TSEL_W'(t)),
            .load_val (wr_data[31:16]),
            .sync     (ctrl_we && cmd[2]),
            .expire   (expire_vec[t])
        );
    end

    for (genvar p = 0; p < NPROC; p++) begin : g_proc
        proc_entry u_ent (
            .clk        (clk),
            .rst_n      (rst_n),
            .tick       (tick_ms),
            .expire_vec (expire_vec),
            .bind_we    (bind_we && upper_sel == PIDX_W'(p)),
            .bind_val   (wr_data[TSEL_W-1:0]),
            .delay_we   (delay_we && upper_sel == PIDX_W'(p)),
            .delay_val  (wr_data[15:0]),
            .cancel     (ctrl_we && cmd[0] && cancel_sel == PIDX_W'(p)),
            .clr        (clr_we && wr_data[p]),
            .ready      (ready_word[p])
        );
    end

    // R4: a reset-all leaves no expiry in flight
    a_r4_sync_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && cmd[2]) |=> (expire_vec == '0));
    // R1: reset leaves flags clear
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (ready_word == '0));
endmodule

// File: tb/slot_sched_test.sv
module slot_sched_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_ms = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] ready_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    slot_sched uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ready_word(ready_word)
    );

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick_ms = 1'b1;
            @(negedge clk);
            tick_ms = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input int bitn, input logic exp);
        checks++;
        if (ready_word[bitn] !== exp) begin
            fails++;
            $display("FAIL %s: ready[%0d] actual %0b expected %0b", req, bitn, ready_word[bitn], exp);
        end
    endtask

    task automatic load(input int t, input int per);
        wr(2'd0, (32'(per) << 16) | (32'(t) << 8) | 32'h2);
    endtask

    task automatic bind_p(input int p, input int t);
        wr(2'd1, (32'(p) << 16) | 32'(t));
    endtask

    task automatic t_reset;
        checks++;
        if (ready_word !== 32'h0) begin
            fails++;
            $display("FAIL R1: ready_word actual %h expected 0", ready_word);
        end
    endtask

    task automatic t_period;
        bind_p(0, 0);
        load(0, 3);
        ticks(2); chk("R2", 0, 1'b0);
        ticks(1); chk("R2", 0, 1'b1);
        wr(2'd3, 32'h0); chk("R6", 0, 1'b1);
        wr(2'd3, 32'h1); chk("R6", 0, 1'b0);
        ticks(3); chk("R2", 0, 1'b1);
        ticks(3); chk("R7", 0, 1'b1);
        wr(2'd3, 32'h1); chk("R7", 0, 1'b0);
        load(0, 0);
        wr(2'd3, 32'hFFFF_FFFF);
    endtask

    task automatic t_zero;
        bind_p(1, 1);
        ticks(5); chk("R3", 1, 1'b0);
        load(1, 2);
        ticks(2); chk("R3", 1, 1'b1);
        load(1, 0);
        wr(2'd3, 32'h2);
        ticks(4); chk("R3", 1, 1'b0);
    endtask

    task automatic t_bind;
        bind_p(2, 2); bind_p(3, 3);
        load(2, 5); load(3, 2);
        wr(2'd3, 32'hC);
        ticks(2);
        chk("R5", 3, 1'b1); chk("R5", 2, 1'b0);
    endtask

    task automatic t_sync;
        bind_p(4, 4);
        load(2, 4);
        ticks(2);
        load(4, 4);
        wr(2'd0, 32'h4);
        wr(2'd3, 32'h14);
        ticks(3); chk("R4", 2, 1'b0); chk("R4", 4, 1'b0);
        ticks(1); chk("R4", 2, 1'b1); chk("R4", 4, 1'b1);
        load(2, 0); load(4, 0); load(3, 0);
    endtask

    task automatic t_delay;
        bind_p(5, 5);
        load(5, 2);
        wr(2'd0, 32'h4);
        wr(2'd3, 32'h20);
        wr(2'd2, (32'd5 << 16) | 32'd5);
        ticks(4); chk("R8", 5, 1'b0);
        ticks(1); chk("R8", 5, 1'b1);
        wr(2'd3, 32'h20);
        ticks(1); chk("R8", 5, 1'b1);
        load(5, 0);
    endtask

    task automatic t_cancel;
        bind_p(6, 6);
        wr(2'd3, 32'h40);
        wr(2'd2, (32'd6 << 16) | 32'd3);
        ticks(2);
        wr(2'd0, (32'd6 << 8) | 32'h1);
        chk("R9", 6, 1'b0);
        ticks(3); chk("R9", 6, 1'b0);
        load(6, 1);
        ticks(1); chk("R9", 6, 1'b1);
        load(6, 0);
    endtask

    task automatic t_zero_delay;
        bind_p(7, 7);
        wr(2'd3, 32'h80);
        chk("R10", 7, 1'b0);
        wr(2'd2, (32'd7 << 16));
        chk("R10", 7, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_period;
        t_zero;
        t_bind;
        t_sync;
        t_delay;
        t_cancel;
        t_zero_delay;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule